// File: doc/BRIEF.md
# Serial Port Register and Interrupt Front End

This block is the register-side half of a byte-oriented serial port. A processor reaches it through a 32-bit word-addressed read/write port, and a single level interrupt tells it when something needs attention. On its other side the block hands bytes to an ideal transmit channel as a one-cycle valid pulse with data. It takes bytes from an ideal receive channel through a valid/ready pair. Bit timing, baud generation, DMA and queuing all live elsewhere.

Software writes a byte to the data-out offset to send it. It reads incoming bytes and flags from a status word that has two aliases: the popping alias clears the data-available flag as a side effect of the read, and the peeking alias leaves it alone. Interrupt causes collect in a raw register. They are gated by a mask and cleared by writing ones to an acknowledge offset, which always reads back zero. A two-state transmit tracker, TX_QUIET and TX_ARMED, makes the transmit cause survive the first acknowledge that follows a data-out write.

Tracker transitions:
- TX_QUIET goes to TX_ARMED on a data-out write.
- TX_ARMED goes to TX_QUIET on an acknowledge write with bit 0 set.
- Every other cycle, the tracker stays where it is.

Top module: `sio_reg_front`

## Requirements
- R1: After reset, both status aliases (byte offsets 0x20 and 0x24) read 0x0140_0000, which is transmitter-ready at bit 24 and transmitter-idle at bit 22. Every other register reads zero, irq is low and rx_ready is high.
- R2: The transmit control (0x00), transmit DMA enable (0x04) and interrupt mask (0x2C) offsets read back the last full word written. Reads of receive control (0x08), data out (0x1C), acknowledge (0x30) and any unmapped offset return zero. Writes to the raw interrupt offset (0x34), the status aliases or unmapped offsets change nothing.
- R3: A write to data out (0x1C) produces tx_valid high for exactly the next cycle, with tx_data equal to the written bits 7:0. It also sets raw interrupt bit 0 (read at 0x34).
- R4: A received byte that is accepted (rx_valid and rx_ready high together) replaces status bits 7:0, sets data-available (bit 16) and sets raw interrupt bit 3.
- R5: A read at 0x20 returns the current status word and clears data-available afterwards. A read at 0x24 returns the same word and leaves it unchanged.
- R6: A write to acknowledge (0x30) clears each raw interrupt bit written as one, subject to R7.
- R7: The first acknowledge with bit 0 set after a data-out write leaves raw bit 0 set and consumes the pending state. The next such acknowledge clears raw bit 0.
- R8: The masked interrupt offset (0x38) reads raw AND mask. irq is high exactly when that value is nonzero, and it reflects a write or accepted byte from the following cycle.
- R9: rx_ready is high when receive-control bit 0 is set or raw bit 3 is clear. A byte presented while rx_ready is low leaves the status word unchanged.
- R10: When a register access and an accepted byte fall in the same cycle, the byte's effects land after the access. An acknowledge of bit 3 then leaves bit 3 set, and a popping read still leaves data-available set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the register (word aligned) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| irq | output | 1 | Level interrupt |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_data | output | 8 | Transmit byte |
| rx_valid | input | 1 | Receive byte offered |
| rx_data | input | 8 | Receive byte |
| rx_ready | output | 1 | Receive byte can be accepted |

## Verification
A tracker stuck in the wrong state shows on the port as a raw bit 0 that clears on the first acknowledge, or one that survives the second acknowledge. The next read of offset 0x34 exposes it, one cycle after the write. A data-available flag with the wrong value shows in the very next status read: a popping read that fails to clear it, or a peek that clears it. It can also show as rx_ready staying low after an acknowledge. Errors in ordering when a byte and a write collide surface one cycle later, as a missing raw bit 3 or a wrong byte.

// File: rtl/sio_pkg.sv
package sio_pkg;

    // Byte offsets of the register slots
    localparam int unsigned OFF_TX_CTL    = 'h00;
    localparam int unsigned OFF_TX_DMA    = 'h04;
    localparam int unsigned OFF_RX_CTL    = 'h08;
    localparam int unsigned OFF_DOUT      = 'h1C;
    localparam int unsigned OFF_STAT_POP  = 'h20;
    localparam int unsigned OFF_STAT_PEEK = 'h24;
    localparam int unsigned OFF_IMASK     = 'h2C;
    localparam int unsigned OFF_IACK      = 'h30;
    localparam int unsigned OFF_IRAW      = 'h34;
    localparam int unsigned OFF_IMASKED   = 'h38;

    // Status word bit positions
    localparam int unsigned BIT_DAV     = 16;
    localparam int unsigned BIT_TX_IDLE = 22;
    localparam int unsigned BIT_TX_RDY  = 24;

    // Interrupt cause positions
    localparam int unsigned CAUSE_TX = 0;
    localparam int unsigned CAUSE_RX = 3;

    typedef enum logic [0:0] {
        TX_QUIET = 1'b0,
        TX_ARMED = 1'b1
    } tx_state_e;

    typedef struct packed {
        logic wr_tx_ctl;
        logic wr_tx_dma;
        logic wr_rx_ctl;
        logic wr_dout;
        logic wr_imask;
        logic wr_iack;
        logic rd_pop;
    } sio_strobe_t;

endpackage

// File: rtl/sio_decode.sv
module sio_decode
    import sio_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output sio_strobe_t       stb
);

    logic wr_any;
    logic rd_any;

    assign wr_any = sel & wr;
    assign rd_any = sel & ~wr;

    always_comb begin
        stb           = '0;
        stb.wr_tx_ctl = wr_any && (addr == ADDR_W'(OFF_TX_CTL));
        stb.wr_tx_dma = wr_any && (addr == ADDR_W'(OFF_TX_DMA));
        stb.wr_rx_ctl = wr_any && (addr == ADDR_W'(OFF_RX_CTL));
        stb.wr_dout   = wr_any && (addr == ADDR_W'(OFF_DOUT));
        stb.wr_imask  = wr_any && (addr == ADDR_W'(OFF_IMASK));
        stb.wr_iack   = wr_any && (addr == ADDR_W'(OFF_IACK));
        stb.rd_pop    = rd_any && (addr == ADDR_W'(OFF_STAT_POP));
    end

endmodule

// File: rtl/sio_txctl.sv
module sio_txctl
    import sio_pkg::*;
#(
    parameter int DW     = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_dout,
    input  logic              wr_iack,
    input  logic [DW-1:0]     wdata,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    output logic [DW-1:0]     ack_eff,
    output logic              armed
);

    tx_state_e state_q;
    tx_state_e state_d;
    logic      consume;

    assign consume = wr_iack & wdata[CAUSE_TX];

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_QUIET: if (wr_dout) state_d = TX_ARMED;
            TX_ARMED: if (consume) state_d = TX_QUIET;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TX_QUIET;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        ack_eff = wdata;
        if (state_q == TX_ARMED && consume) ack_eff[CAUSE_TX] = 1'b0;
    end

    assign armed = (state_q == TX_ARMED);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_data  <= '0;
        end else begin
            tx_valid <= wr_dout;
            if (wr_dout) tx_data <= wdata[BYTE_W-1:0];
        end
    end

endmodule

// File: rtl/sio_intc.sv
module sio_intc
    import sio_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_imask,
    input  logic          wr_iack,
    input  logic          set_tx,
    input  logic          set_rx,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] ack_eff,
    output logic [DW-1:0] raw_q,
    output logic [DW-1:0] mask_q,
    output logic [DW-1:0] masked,
    output logic          irq
);

    logic [DW-1:0] raw_d;

    // ordering: transmit set, then acknowledge, then receive set
    always_comb begin
        raw_d = raw_q;
        if (set_tx)  raw_d[CAUSE_TX] = 1'b1;
        if (wr_iack) raw_d = raw_d & ~ack_eff;
        if (set_rx)  raw_d[CAUSE_RX] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q  <= '0;
            mask_q <= '0;
        end else begin
            raw_q <= raw_d;
            if (wr_imask) mask_q <= wdata;
        end
    end

    assign masked = raw_q & mask_q;
    assign irq    = |masked;

endmodule

// File: rtl/sio_rxstat.sv
module sio_rxstat #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              pop,
    output logic [BYTE_W-1:0] byte_q,
    output logic              dav_q,
    output logic              tx_idle_q,
    output logic              tx_rdy_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_q    <= '0;
            dav_q     <= 1'b0;
            tx_idle_q <= 1'b1;
            tx_rdy_q  <= 1'b1;
        end else begin
            // pop clears first, a byte in the same cycle sets again
            if (pop) dav_q <= 1'b0;
            if (take) begin
                byte_q <= byte_in;
                dav_q  <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/sio_reg_front.sv
module sio_reg_front
    import sio_pkg::*;
#(
    parameter int DW     = 32,
    parameter int ADDR_W = 6,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              irq,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              rx_ready
);

    sio_strobe_t       stb;
    logic [DW-1:0]     tx_ctl_q;
    logic [DW-1:0]     tx_dma_q;
    logic              rx_en_q;
    logic [DW-1:0]     ack_eff;
    logic              tx_armed;
    logic [DW-1:0]     raw_q;
    logic [DW-1:0]     mask_q;
    logic [DW-1:0]     masked;
    logic [BYTE_W-1:0] rx_byte_q;
    logic              dav_q;
    logic              tx_idle_q;
    logic              tx_rdy_q;
    logic              rx_take;
    logic [DW-1:0]     stat_word;

    sio_decode #(.ADDR_W(ADDR_W)) u_dec (
        .sel  (bus_sel),
        .wr   (bus_wr),
        .addr (bus_addr),
        .stb  (stb)
    );

    sio_txctl #(.DW(DW), .BYTE_W(BYTE_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_dout  (stb.wr_dout),
        .wr_iack  (stb.wr_iack),
        .wdata    (bus_wdata),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .ack_eff  (ack_eff),
        .armed    (tx_armed)
    );

    assign rx_ready = rx_en_q | ~raw_q[CAUSE_RX];
    assign rx_take  = rx_valid & rx_ready;

    sio_intc #(.DW(DW)) u_intc (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_imask (stb.wr_imask),
        .wr_iack  (stb.wr_iack),
        .set_tx   (stb.wr_dout),
        .set_rx   (rx_take),
        .wdata    (bus_wdata),
        .ack_eff  (ack_eff),
        .raw_q    (raw_q),
        .mask_q   (mask_q),
        .masked   (masked),
        .irq      (irq)
    );

    sio_rxstat #(.BYTE_W(BYTE_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (rx_take),
        .byte_in   (rx_data),
        .pop       (stb.rd_pop),
        .byte_q    (rx_byte_q),
        .dav_q     (dav_q),
        .tx_idle_q (tx_idle_q),
        .tx_rdy_q  (tx_rdy_q)
    );

    // plain control registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_ctl_q <= '0;
            tx_dma_q <= '0;
            rx_en_q  <= 1'b0;
        end else begin
            if (stb.wr_tx_ctl) tx_ctl_q <= bus_wdata;
            if (stb.wr_tx_dma) tx_dma_q <= bus_wdata;
            if (stb.wr_rx_ctl) rx_en_q  <= bus_wdata[0];
        end
    end

    always_comb begin
        stat_word               = '0;
        stat_word[BYTE_W-1:0]   = rx_byte_q;
        stat_word[BIT_DAV]      = dav_q;
        stat_word[BIT_TX_IDLE]  = tx_idle_q;
        stat_word[BIT_TX_RDY]   = tx_rdy_q;
    end

    // read mux (combinational, side effects land at the clock edge)
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (bus_addr)
                ADDR_W'(OFF_TX_CTL):    bus_rdata = tx_ctl_q;
                ADDR_W'(OFF_TX_DMA):    bus_rdata = tx_dma_q;
                ADDR_W'(OFF_STAT_POP):  bus_rdata = stat_word;
                ADDR_W'(OFF_STAT_PEEK): bus_rdata = stat_word;
                ADDR_W'(OFF_IMASK):     bus_rdata = mask_q;
                ADDR_W'(OFF_IRAW):      bus_rdata = raw_q;
                ADDR_W'(OFF_IMASKED):   bus_rdata = masked;
                default:                bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/sio_reg_front_chk.sv
module sio_reg_front_chk
    import sio_pkg::*;
#(
    parameter int DW     = 32,
    parameter int ADDR_W = 6,
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DW-1:0]     bus_wdata,
    input logic              irq,
    input logic              tx_valid,
    input logic [BYTE_W-1:0] tx_data,
    input logic              rx_valid,
    input logic [BYTE_W-1:0] rx_data,
    input logic              rx_ready,
    input logic [DW-1:0]     raw,
    input logic              dav,
    input logic [BYTE_W-1:0] rbyte,
    input logic              armed
);

    logic c_dout, c_ack, c_mask, c_pop;
    assign c_dout = bus_sel && bus_wr && bus_addr == ADDR_W'(OFF_DOUT);
    assign c_ack  = bus_sel && bus_wr && bus_addr == ADDR_W'(OFF_IACK);
    assign c_mask = bus_sel && bus_wr && bus_addr == ADDR_W'(OFF_IMASK);
    assign c_pop  = bus_sel && !bus_wr && bus_addr == ADDR_W'(OFF_STAT_POP);

    assert_tx_emit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        c_dout |=> tx_valid && tx_data == $past(bus_wdata[BYTE_W-1:0]));

    assert_tx_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !c_dout |=> !tx_valid);

    assert_rx_take_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && rx_ready |=> dav && raw[CAUSE_RX] && rbyte == $past(rx_data));

    assert_pop_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        c_pop && !rx_valid |=> !dav);

    assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        c_ack && bus_wdata[CAUSE_RX] && !rx_valid |=> !raw[CAUSE_RX]);

    assert_rearm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        armed && c_ack && bus_wdata[CAUSE_TX] |=> raw[CAUSE_TX] && !armed);

    assert_mask_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        c_mask && bus_wdata == '0 |=> !irq);

    assert_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !raw[CAUSE_RX] |-> rx_ready);

    assert_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && !rx_ready |=> $stable(rbyte));

    assert_collide_R10: assert property (@(posedge clk) disable iff (!rst_n)
        c_pop && rx_valid && rx_ready |=> dav);

endmodule

bind sio_reg_front sio_reg_front_chk #(.DW(DW), .ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .rx_ready  (rx_ready),
    .raw       (raw_q),
    .dav       (dav_q),
    .rbyte     (rx_byte_q),
    .armed     (tx_armed)
);

// File: tb/sio_reg_front_test.sv
`timescale 1ns/1ps
module sio_reg_front_test;

    localparam int K_RD  = 0;
    localparam int K_IRQ = 1;
    localparam int K_TX  = 2;
    localparam int K_RDY = 3;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_sel, bus_wr;
    logic [5:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        irq, tx_valid, rx_valid, rx_ready;
    logic [7:0]  tx_data, rx_data;

    item_t q[$];
    int    nvec  = 0;
    int    nfail = 0;
    bit    done  = 0;

    always #2.5 clk = ~clk;

    sio_reg_front uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .tx_valid(tx_valid), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready)
    );

    // monitor: compares every queued expectation just before the rising edge
    always @(negedge clk) begin
        item_t       it;
        logic [31:0] act;
        #2;
        while (q.size() > 0) begin
            it = q.pop_front();
            case (it.kind)
                K_RD:    act = bus_rdata;
                K_IRQ:   act = {31'b0, irq};
                K_TX:    act = tx_valid ? {23'b0, 1'b1, tx_data} : 32'h0;
                default: act = {31'b0, rx_ready};
            endcase
            nvec++;
            if (act !== it.exp) begin
                nfail++;
                $display("FAIL %s: got %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic push(int kind, logic [31:0] exp, string tag);
        item_t it;
        it.kind = kind; it.exp = exp; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic idle_in();
        bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
        rx_valid = 0; rx_data = '0;
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] d);
        idle_in(); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
    endtask

    task automatic rd(logic [5:0] a, logic [31:0] exp, string tag);
        idle_in(); bus_sel = 1; bus_addr = a;
        push(K_RD, exp, tag);
        @(negedge clk);
    endtask

    task automatic chk(int kind, logic [31:0] exp, string tag);
        idle_in(); push(kind, exp, tag);
        @(negedge clk);
    endtask

    task automatic rx(logic [7:0] b);
        idle_in(); rx_valid = 1; rx_data = b;
        @(negedge clk);
    endtask

    task automatic wr_rx(logic [5:0] a, logic [31:0] d, logic [7:0] b);
        idle_in(); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        rx_valid = 1; rx_data = b;
        @(negedge clk);
    endtask

    task automatic rd_rx(logic [5:0] a, logic [31:0] exp, logic [7:0] b, string tag);
        idle_in(); bus_sel = 1; bus_addr = a; rx_valid = 1; rx_data = b;
        push(K_RD, exp, tag);
        @(negedge clk);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        idle_in();
        rst_n = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        rd(6'h20, 32'h0140_0000, "R1 status pop");
        rd(6'h24, 32'h0140_0000, "R1 status peek");
        rd(6'h34, 32'h0, "R1 raw");
        rd(6'h2C, 32'h0, "R1 mask");
        rd(6'h38, 32'h0, "R1 masked");
        chk(K_IRQ, 0, "R1 irq");
        chk(K_RDY, 1, "R1 rx_ready");

        // R2 plain registers and ignored accesses
        wr(6'h00, 32'hA5A5_0001); rd(6'h00, 32'hA5A5_0001, "R2 tx ctl");
        wr(6'h04, 32'h0000_0003); rd(6'h04, 32'h0000_0003, "R2 tx dma");
        wr(6'h08, 32'h1);         rd(6'h08, 32'h0, "R2 rx ctl reads zero");
        wr(6'h08, 32'h0);
        rd(6'h1C, 32'h0, "R2 dout reads zero");
        rd(6'h3C, 32'h0, "R2 unmapped");
        wr(6'h34, 32'hFFFF_FFFF); rd(6'h34, 32'h0, "R2 raw write ignored");
        wr(6'h24, 32'hFFFF_FFFF); rd(6'h24, 32'h0140_0000, "R2 status write ignored");

        // R3 transmit
        wr(6'h1C, 32'h1234_56C3);
        chk(K_TX, 32'h1C3, "R3 tx pulse");
        chk(K_TX, 32'h0, "R3 tx single cycle");
        rd(6'h34, 32'h1, "R3 raw tx cause");
        chk(K_IRQ, 0, "R8 irq masked off");

        // R8 mask
        wr(6'h2C, 32'h9);
        chk(K_IRQ, 1, "R8 irq on mask");
        rd(6'h38, 32'h1, "R8 masked");

        // R7 re-arm, R6 ack reads zero
        wr(6'h30, 32'h1);
        rd(6'h34, 32'h1, "R7 first ack keeps tx cause");
        chk(K_IRQ, 1, "R7 irq still high");
        wr(6'h30, 32'h1);
        rd(6'h34, 32'h0, "R7 second ack clears");
        chk(K_IRQ, 0, "R7 irq low");
        rd(6'h30, 32'h0, "R6 ack reads zero");

        // R4 receive
        rx(8'h5A);
        rd(6'h24, 32'h0141_005A, "R4 status after byte");
        rd(6'h34, 32'h8, "R4 raw rx cause");
        chk(K_IRQ, 1, "R8 irq on rx");
        chk(K_RDY, 0, "R9 not ready");

        // R9 drop and enable
        rx(8'h77);
        rd(6'h24, 32'h0141_005A, "R9 dropped byte");
        wr(6'h08, 32'h1);
        chk(K_RDY, 1, "R9 ready via rx ctl");
        rx(8'h77);
        rd(6'h24, 32'h0141_0077, "R5 peek keeps dav");
        rd(6'h24, 32'h0141_0077, "R5 peek again");

        // R5 pop
        rd(6'h20, 32'h0141_0077, "R5 pop returns word");
        rd(6'h20, 32'h0140_0077, "R5 dav cleared");
        rd(6'h24, 32'h0140_0077, "R5 peek after pop");

        // R6 ack rx cause
        wr(6'h30, 32'h8);
        rd(6'h34, 32'h0, "R6 rx cause cleared");
        chk(K_IRQ, 0, "R6 irq low");
        rd(6'h38, 32'h0, "R6 masked zero");

        // R10 collisions
        rx(8'h11);
        wr_rx(6'h30, 32'h8, 8'h22);
        rd(6'h34, 32'h8, "R10 byte wins over ack");
        rd(6'h24, 32'h0141_0022, "R10 byte stored");
        rd_rx(6'h20, 32'h0141_0022, 8'h33, "R10 pop with byte");
        rd(6'h24, 32'h0141_0033, "R10 dav set after pop");

        // R8 mask cleared
        wr(6'h2C, 32'h0);
        chk(K_IRQ, 0, "R8 irq mask zero");
        rd(6'h38, 32'h0, "R8 masked zero");

        idle_in();
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule